// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one pointer event into a five-byte serial mouse packet. It takes two signed motion deltas and three button states. It then pushes the packet one byte at a time into a downstream receive byte queue. Events arrive over a valid/ready handshake. The block holds only one event at a time and stays busy until every byte of the packet has left.

The first byte of the packet is a start marker. Its three low bits carry the buttons in active-low form. The X motion follows, then the Y motion with its sign flipped, and then two zero bytes that pad the packet to its full length. Each motion value is clamped to a symmetric signed range before it is cut down to a byte. The queue side is a push strobe with a byte. A full flag from the queue freezes the output, so no byte is ever lost and no packet is ever split.

Top module: `mouse_pkt_encoder`

## Requirements
- R1: After a synchronous reset, `ev_ready` is 1 and `q_push` is 0.
- R2: The head byte is 0x87 with bits cleared for pressed buttons. `ev_btn[2]` (left) clears bit 2, `ev_btn[1]` (middle) clears bit 1 and `ev_btn[0]` (right) clears bit 0. A button bit of 1 means pressed.
- R3: The X byte is `ev_dx` clamped to the range -127..+127, in two's complement. An input of -128 or lower gives 0x81, and +127 or higher gives 0x7F.
- R4: The Y byte is the negation of `ev_dy`, clamped to -127..+127. An `ev_dy` of -32768 gives 0x7F, and +128 gives 0x81.
- R5: The fourth and fifth bytes of every packet are 0x00.
- R6: The bytes leave in the order head, X, Y, zero, zero. A byte is transferred in each cycle where `q_push` is 1 and `q_full` is 0.
- R7: An event is taken only in a cycle where both `ev_valid` and `ev_ready` are 1. `ev_ready` stays 0 from that acceptance until the fifth byte is transferred, and input changes during that time do not alter the packet.
- R8: While `q_push` is 1 and `q_full` is 1, the next cycle holds `q_push` at 1 and keeps `q_byte` unchanged.
- R9: In the cycle after the fifth byte is transferred, `ev_ready` is 1 and `q_push` is 0. A waiting event is then accepted at once, so packets can follow every six cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Encoder can take an event |
| ev_dx | input | DELTA_W | Signed X motion |
| ev_dy | input | DELTA_W | Signed Y motion |
| ev_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| q_full | input | 1 | Downstream queue cannot take a byte |
| q_push | output | 1 | Byte offered to the queue |
| q_byte | output | 8 | Packet byte |

## Verification
Two things can happen in the same cycle. The queue can report full while the fifth byte is on offer, and at that moment the next event is already waiting on `ev_valid`. To provoke this, the bench holds a second event with different values on the input for the whole time the first packet is being emitted. It also raises `q_full` for two cycles exactly when the last padding byte is offered. The result is judged correct under three conditions. `ev_ready` must stay low through the stall. The padding byte must be repeated unchanged. The second packet must then start one cycle after the real final transfer and carry its own values.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int BYTE_W = 8;

  // packet slot sequence; order is the wire order
  typedef enum logic [2:0] {
    SLOT_HEAD = 3'd0,
    SLOT_X    = 3'd1,
    SLOT_Y    = 3'd2,
    SLOT_PAD0 = 3'd3,
    SLOT_PAD1 = 3'd4
  } slot_e;

  // start marker with active-low buttons: {left, middle, right}
  function automatic logic [BYTE_W-1:0] head_byte(input logic [2:0] btn);
    return {1'b1, 4'b0000, ~btn};
  endfunction
endpackage

// File: rtl/mp_clamp.sv
module mp_clamp #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 8,
  parameter bit NEGATE = 1'b0
) (
  input  logic [IN_W-1:0]  d_in,
  output logic [OUT_W-1:0] d_out
);
  localparam int                    LIM = (2 ** (OUT_W - 1)) - 1;
  localparam logic signed [IN_W:0]  HI  = (IN_W + 1)'(LIM);
  localparam logic signed [IN_W:0]  LO  = -HI;

  logic signed [IN_W:0] wide;

  // one extra bit so that negating the most negative input cannot wrap
  generate
    if (NEGATE) begin : g_neg
      assign wide = -$signed({d_in[IN_W-1], d_in});
    end else begin : g_pass
      assign wide = $signed({d_in[IN_W-1], d_in});
    end
  endgenerate

  always_comb begin
    if (wide > HI)      d_out = HI[OUT_W-1:0];
    else if (wide < LO) d_out = LO[OUT_W-1:0];
    else                d_out = wide[OUT_W-1:0];
  end
endmodule

// File: rtl/mp_seq.sv
module mp_seq
  import mp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [BYTE_W-1:0] head_in,
  input  logic [BYTE_W-1:0] x_in,
  input  logic [BYTE_W-1:0] y_in,
  input  logic              q_full,
  output logic              q_push,
  output logic [BYTE_W-1:0] q_byte
);
  slot_e             slot_q;
  logic              rdy_q, push_q;
  logic [BYTE_W-1:0] byte_q, x_q, y_q, next_byte;
  logic              take, xfer;

  assign take = ev_valid && rdy_q;
  assign xfer = push_q && !q_full;

  always_comb begin
    case (slot_q)
      SLOT_HEAD: next_byte = x_q;
      SLOT_X:    next_byte = y_q;
      default:   next_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= 1'b1;
      push_q <= 1'b0;
      slot_q <= SLOT_HEAD;
      byte_q <= '0;
      x_q    <= '0;
      y_q    <= '0;
    end else if (take) begin
      rdy_q  <= 1'b0;
      push_q <= 1'b1;
      slot_q <= SLOT_HEAD;
      byte_q <= head_in;
      x_q    <= x_in;
      y_q    <= y_in;
    end else if (xfer) begin
      if (slot_q == SLOT_PAD1) begin
        push_q <= 1'b0;
        rdy_q  <= 1'b1;
      end else begin
        slot_q <= slot_e'(slot_q + 3'd1);
        byte_q <= next_byte;
      end
    end
  end

  assign ev_ready = rdy_q;
  assign q_push   = push_q;
  assign q_byte   = byte_q;

  // R2: head byte carries the fixed marker bits
  p_head_marker_r2: assert property (@(posedge clk) disable iff (rst)
    (push_q && slot_q == SLOT_HEAD) |-> (byte_q[7:3] == 5'b10000));
  // R3: X byte never takes the unclamped minimum
  p_x_range_r3: assert property (@(posedge clk) disable iff (rst)
    (push_q && slot_q == SLOT_X) |-> (byte_q != 8'h80));
  // R4: Y byte never takes the unclamped minimum
  p_y_range_r4: assert property (@(posedge clk) disable iff (rst)
    (push_q && slot_q == SLOT_Y) |-> (byte_q != 8'h80));
  // R5: padding slots offer zero
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (push_q && (slot_q == SLOT_PAD0 || slot_q == SLOT_PAD1)) |-> (byte_q == '0));
  // R6: acceptance starts a packet with the head slot
  p_start_head_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> (push_q && slot_q == SLOT_HEAD));
  // R7: no new event while a packet is on offer
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    push_q |-> !rdy_q);
  // R8: a full queue freezes the offered byte
  p_hold_on_full_r8: assert property (@(posedge clk) disable iff (rst)
    (push_q && q_full) |=> (push_q && $stable(byte_q)));
  // R9: final transfer frees the input side
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (xfer && slot_q == SLOT_PAD1) |=> (rdy_q && !push_q));
endmodule

// File: rtl/mouse_pkt_encoder.sv
module mouse_pkt_encoder
  import mp_pkg::*;
#(
  parameter int DELTA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic [DELTA_W-1:0] ev_dx,
  input  logic [DELTA_W-1:0] ev_dy,
  input  logic [2:0]         ev_btn,
  input  logic               q_full,
  output logic               q_push,
  output logic [BYTE_W-1:0]  q_byte
);
  logic [BYTE_W-1:0] x_sat, y_sat, head;

  assign head = head_byte(ev_btn);

  mp_clamp #(.IN_W(DELTA_W), .OUT_W(BYTE_W), .NEGATE(1'b0)) i_clamp_x (
    .d_in (ev_dx),
    .d_out(x_sat)
  );

  mp_clamp #(.IN_W(DELTA_W), .OUT_W(BYTE_W), .NEGATE(1'b1)) i_clamp_y (
    .d_in (ev_dy),
    .d_out(y_sat)
  );

  mp_seq i_seq (
    .clk     (clk),
    .rst     (rst),
    .ev_valid(ev_valid),
    .ev_ready(ev_ready),
    .head_in (head),
    .x_in    (x_sat),
    .y_in    (y_sat),
    .q_full  (q_full),
    .q_push  (q_push),
    .q_byte  (q_byte)
  );
endmodule

// File: tb/test_mouse_pkt_encoder.sv
module test_mouse_pkt_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [15:0] ev_dx = '0;
  logic [15:0] ev_dy = '0;
  logic [2:0]  ev_btn = '0;
  logic        q_full = 1'b0;
  logic        q_push;
  logic [7:0]  q_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mouse_pkt_encoder #(.DELTA_W(16)) i_mouse_pkt_encoder (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_dx(ev_dx), .ev_dy(ev_dy), .ev_btn(ev_btn),
    .q_full(q_full), .q_push(q_push), .q_byte(q_byte)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] sat8(input int v);
    if (v > 127)  return 8'h7F;
    if (v < -127) return 8'h81;
    return v[7:0];
  endfunction

  // Caller stands at a negedge. Offers the event, collects five bytes with the
  // given stall mask (bit n = q_full during collection cycle n), and returns at
  // the negedge after the final transfer. If hold_next, valid stays high with
  // the next event's values after acceptance.
  task automatic run_packet(input logic [15:0] dx, input logic [15:0] dy,
                            input logic [2:0] btn, input logic [15:0] stall,
                            input bit hold_next, input logic [15:0] ndx,
                            input logic [15:0] ndy, input logic [2:0] nbtn);
    logic [7:0] exp_b [5];
    logic [7:0] held;
    bit         was_stalled;
    int         got;
    int         cyc;
    string      tags [5];
    tags[0] = "R2 head"; tags[1] = "R3 x"; tags[2] = "R4 y";
    tags[3] = "R5 pad0"; tags[4] = "R5 pad1";
    exp_b[0] = 8'h87 ^ {5'b0, btn};
    exp_b[1] = sat8(int'($signed(dx)));
    exp_b[2] = sat8(-int'($signed(dy)));
    exp_b[3] = 8'h00;
    exp_b[4] = 8'h00;
    ev_valid = 1'b1; ev_dx = dx; ev_dy = dy; ev_btn = btn;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    if (hold_next) begin
      ev_dx = ndx; ev_dy = ndy; ev_btn = nbtn;
    end else begin
      ev_valid = 1'b0;
    end
    chk(q_push === 1'b1, "R6 push after accept", int'(q_push), 1);
    got = 0; cyc = 0; was_stalled = 1'b0; held = '0;
    while (got < 5 && cyc < 64) begin
      q_full = (cyc < 16) ? stall[cyc] : 1'b0;
      chk(ev_ready === 1'b0, "R7 ready low while busy", int'(ev_ready), 0);
      if (was_stalled)
        chk(q_push === 1'b1 && q_byte === held, "R8 byte held on full", int'(q_byte), int'(held));
      if (q_push && !q_full) begin
        chk(q_byte === exp_b[got], {tags[got], " R6 order"}, int'(q_byte), int'(exp_b[got]));
        got++;
        was_stalled = 1'b0;
      end else begin
        was_stalled = q_push && q_full;
        held = q_byte;
      end
      cyc++;
      @(negedge clk);
    end
    q_full = 1'b0;
    chk(got == 5, "R6 five bytes", got, 5);
    chk(ev_ready === 1'b1 && q_push === 1'b0, "R9 release after last byte",
        int'({ev_ready, q_push}), 2);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ev_ready === 1'b1, "R1 ready after reset", int'(ev_ready), 1);
    chk(q_push === 1'b0, "R1 no push after reset", int'(q_push), 0);
  endtask

  task automatic t_basic;
    run_packet(16'd5, 16'd3, 3'b000, 16'h0, 1'b0, 0, 0, 0);
    run_packet(-16'sd9, -16'sd20, 3'b000, 16'h0, 1'b0, 0, 0, 0);
  endtask

  task automatic t_buttons;
    run_packet(16'd1, 16'd1, 3'b100, 16'h0, 1'b0, 0, 0, 0);
    run_packet(16'd1, 16'd1, 3'b010, 16'h0, 1'b0, 0, 0, 0);
    run_packet(16'd1, 16'd1, 3'b001, 16'h0, 1'b0, 0, 0, 0);
    run_packet(16'd1, 16'd1, 3'b111, 16'h0, 1'b0, 0, 0, 0);
  endtask

  task automatic t_saturation;
    run_packet(16'd300, -16'sd300, 3'b000, 16'h0, 1'b0, 0, 0, 0);
    run_packet(-16'sd128, 16'd128, 3'b000, 16'h0, 1'b0, 0, 0, 0);
    run_packet(16'h8000, 16'h8000, 3'b000, 16'h0, 1'b0, 0, 0, 0);
    run_packet(16'd127, -16'sd127, 3'b000, 16'h0, 1'b0, 0, 0, 0);
    run_packet(-16'sd127, 16'd127, 3'b000, 16'h0, 1'b0, 0, 0, 0);
    run_packet(16'h7FFF, 16'd0, 3'b000, 16'h0, 1'b0, 0, 0, 0);
  endtask

  task automatic t_stalls;
    run_packet(16'd40, 16'd60, 3'b101, 16'b0000_0000_0101_0011, 1'b0, 0, 0, 0);
    run_packet(-16'sd2, 16'd2, 3'b010, 16'b0000_0011_1110_0001, 1'b0, 0, 0, 0);
  endtask

  // final byte stalled while the next event waits with valid held high
  task automatic t_back_to_back;
    run_packet(16'd10, 16'd20, 3'b001, 16'b0000_0000_0011_0000, 1'b1,
               -16'sd500, 16'd70, 3'b110);
    chk(ev_valid === 1'b1, "R7 next event still waiting", int'(ev_valid), 1);
    run_packet(-16'sd500, 16'd70, 3'b110, 16'h0, 1'b0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_buttons();
    t_saturation();
    t_stalls();
    t_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule